// File: doc/BRIEF.md
# Programmable Synchronous Serial Port

This block is a synchronous serial port that runs either as the clock-driving end (master) or as the clocked end (slave) of a four-wire SPI-style link. Frames carry between 4 and 16 bits and go out most significant bit first. Clock polarity and clock phase can be set, so all four clocking modes are available. In master mode the bit clock is derived from the block clock by two divider stages in series. The first stage is an even prescaler and the second divides by one plus a rate value.

A plain set of configuration inputs controls the block. These inputs select the divider values, polarity, phase, word size, role, slave output disable, internal loopback and enable. Outgoing words pass through a one-entry holding register with a valid/ready handshake. Each received word appears on the output with a single-cycle valid pulse. In slave mode the incoming clock, select and data lines pass through two-flop synchronizers, and all edge detection happens in the block clock domain.

Top module: `sync_serial_port`

## Requirements
- R1: In master mode each half period of the bit clock lasts P*(RATE+1) block clock cycles, where P = cfg_prescale/2 with the least significant bit dropped; a cfg_prescale below 2 gives P = 1.
- R2: A frame carries cfg_size+1 bits for cfg_size 3..15, and 4 bits for cfg_size 0..2. Bits are sent most significant first, starting from the low bits of the queued word. The received word is right-aligned with zeros above it, and a master frame makes exactly two bit-clock transitions per bit.
- R3: The idle clock level equals cfg_cpol. With cfg_cpha=0, data is captured on the first (leading) edge of each bit. With cfg_cpha=1, data is captured on the second (trailing) edge.
- R4: In master mode ser_sel_n_o is low only while a frame runs, and it falls only in the cycle after a queued word is taken.
- R5: rx_valid is a single-cycle pulse per completed frame, and rx_data holds the received word while it is high.
- R6: tx_ready is high exactly when the holding register is empty. An accepted word makes tx_ready low in the following cycle, and the word is taken when a frame starts. A slave frame that starts with the register empty sends zeros.
- R7: While cfg_en is 0, no frame starts or completes. One cycle after cfg_en falls, ser_sel_n_o is high and rx_valid is low.
- R8: With cfg_slave=1 (0 = master, the reset value), the block is clocked by ser_clk_i and ser_sel_n_i, whose rate is at most one twelfth of the block clock. In this mode ser_sel_n_o stays high and ser_clk_o stays at cfg_cpol.
- R9: With cfg_slave=1 and cfg_slave_tx_off=1, ser_tx_oe and ser_tx_o are 0, and reception is unaffected.
- R10: With cfg_loop=1 the receiver takes the block's own transmit bit instead of the external data input, in either role.
- R11: After reset ser_sel_n_o=1, tx_ready=1, rx_valid=0, ser_clk_o=cfg_cpol and ser_tx_oe=0 while cfg_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Port enable |
| cfg_slave | input | 1 | Role select: 0 master, 1 slave |
| cfg_slave_tx_off | input | 1 | Holds the data output inactive in slave mode |
| cfg_loop | input | 1 | Internal loopback of the transmit bit |
| cfg_cpol | input | 1 | Idle clock level |
| cfg_cpha | input | 1 | Capture edge: 0 leading, 1 trailing |
| cfg_size | input | 4 | Frame length minus one |
| cfg_prescale | input | 8 | First divider stage, even value 2..254 |
| cfg_rate | input | 8 | Second divider stage, divides by value+1 |
| tx_data | input | 16 | Word to send, low bits used |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Holding register is empty |
| rx_data | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle pulse per received word |
| ser_clk_o | output | 1 | Bit clock driven in master mode |
| ser_sel_n_o | output | 1 | Active-low frame select driven in master mode |
| ser_tx_o | output | 1 | Serial data out |
| ser_tx_oe | output | 1 | Output enable for ser_tx_o |
| ser_clk_i | input | 1 | Bit clock received in slave mode |
| ser_sel_n_i | input | 1 | Active-low frame select received in slave mode |
| ser_rx_i | input | 1 | Serial data in |

## Verification
Several properties are checked on every cycle:
- the receive valid pulse lasts one cycle;
- the holding register fills after a handshake, and the frame select falls only after a word is taken;
- disabling the port quiets the frame outputs;
- a disabled slave output stays at zero;
- slave mode leaves the master clock and select at rest.

The bench scenarios cover the remaining behaviour: the bit-clock half period for odd and out-of-range prescale values, the frame lengths including clamped sizes, and the data order in all four clocking modes in both roles. They also cover loopback against an inverted external line and the synchronized slave path driven at a slow external clock.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2
    } eng_state_t;

    typedef struct packed {
        logic lead;
        logic trail;
    } clk_evt_t;

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ssp_baud.sv
module ssp_baud #(
    parameter int PRE_W = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [PRE_W-1:0]  pre_div,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int HW = PRE_W - 1;

    logic [HW-1:0]     half_pre;
    logic [HW-1:0]     pcnt;
    logic [RATE_W-1:0] scnt;

    // even prescaler: low bit dropped, zero half-value clamped to one
    assign half_pre = (pre_div[PRE_W-1:1] == '0) ? HW'(1) : pre_div[PRE_W-1:1];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
            scnt <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (pcnt == half_pre - HW'(1)) begin
                pcnt <= '0;
                if (scnt == rate) begin
                    scnt <= '0;
                    tick <= 1'b1;
                end else begin
                    scnt <= scnt + RATE_W'(1);
                end
            end else begin
                pcnt <= pcnt + HW'(1);
            end
        end
    end
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift
    import ssp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              slave,
    input  logic              cpha,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              start,
    input  logic              abort,
    input  clk_evt_t          evt,
    input  logic              rx_bit,
    input  logic [DATA_W-1:0] load_word,
    output logic              accept,
    output logic              busy,
    output logic              tx_bit,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    eng_state_t        st;
    logic [DATA_W-1:0] tx_sr, rx_sr;
    logic [CNT_W-1:0]  bcnt;
    logic              first;
    logic              sample_ev, shift_ev, last_ev;

    assign sample_ev = cpha ? evt.trail : evt.lead;
    assign shift_ev  = cpha ? (evt.lead && !first) : evt.trail;
    assign accept    = (st == ST_IDLE) && en && start;
    assign busy      = (st == ST_RUN);
    assign tx_bit    = tx_sr[DATA_W-1];

    always_comb begin
        if (slave || cpha) last_ev = sample_ev && (bcnt == nbits - CNT_W'(1));
        else               last_ev = evt.trail && (bcnt == nbits);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            tx_sr   <= '0;
            rx_sr   <= '0;
            bcnt    <= '0;
            first   <= 1'b0;
            done    <= 1'b0;
            rx_word <= '0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                st <= ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: if (start) begin
                        st    <= ST_RUN;
                        tx_sr <= load_word;
                        rx_sr <= '0;
                        bcnt  <= '0;
                        first <= 1'b1;
                    end
                    ST_RUN: if (abort) begin
                        st <= ST_IDLE;
                    end else begin
                        if (shift_ev) tx_sr <= tx_sr << 1;
                        if (evt.lead) first <= 1'b0;
                        if (sample_ev) begin
                            rx_sr <= {rx_sr[DATA_W-2:0], rx_bit};
                            bcnt  <= bcnt + CNT_W'(1);
                        end
                        if (last_ev) begin
                            done    <= 1'b1;
                            rx_word <= sample_ev ? {rx_sr[DATA_W-2:0], rx_bit} : rx_sr;
                            st      <= slave ? ST_WAIT : ST_IDLE;
                        end
                    end
                    ST_WAIT: if (abort) st <= ST_IDLE;
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PRE_W = 8,
    parameter int RATE_W = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SIZE_W = $clog2(DATA_W),
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_slave,
    input  logic              cfg_slave_tx_off,
    input  logic              cfg_loop,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              ser_clk_o,
    output logic              ser_sel_n_o,
    output logic              ser_tx_o,
    output logic              ser_tx_oe,
    input  logic              ser_clk_i,
    input  logic              ser_sel_n_i,
    input  logic              ser_rx_i
);
    logic [CNT_W-1:0]  nbits;
    logic [DATA_W-1:0] hold_q, load_word;
    logic              hold_full, accept, busy, tx_bit, tick, sclk_q;
    logic              s_clk, s_sel, s_rx, s_clk_prev, s_sel_prev;
    logic              start, abort, rx_bit, m_busy;
    clk_evt_t          m_evt, s_evt, evt;

    assign nbits = (cfg_size < SIZE_W'(3)) ? CNT_W'(4) : CNT_W'(cfg_size) + CNT_W'(1);

    // one-entry transmit holding register
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_q    <= '0;
        end else begin
            if (accept) hold_full <= 1'b0;
            if (tx_valid && !hold_full) begin
                hold_full <= 1'b1;
                hold_q    <= tx_data;
            end
        end
    end
    assign tx_ready  = !hold_full;
    assign load_word = hold_full ? (hold_q << (CNT_W'(DATA_W) - nbits)) : '0;

    // slave-side input synchronizers and edge detection
    ssp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
        .clk(clk), .rst(rst),
        .d({ser_clk_i, ser_sel_n_i, ser_rx_i}),
        .q({s_clk, s_sel, s_rx})
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s_clk_prev <= 1'b0;
            s_sel_prev <= 1'b1;
        end else begin
            s_clk_prev <= s_clk;
            s_sel_prev <= s_sel;
        end
    end
    assign s_evt.lead  = !s_sel && (s_clk != s_clk_prev) && (s_clk_prev == cfg_cpol);
    assign s_evt.trail = !s_sel && (s_clk != s_clk_prev) && (s_clk_prev != cfg_cpol);

    // master bit clock
    assign m_busy = busy && !cfg_slave;

    ssp_baud #(.PRE_W(PRE_W), .RATE_W(RATE_W)) i_baud (
        .clk(clk), .rst(rst), .run(m_busy),
        .pre_div(cfg_prescale), .rate(cfg_rate), .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (rst || !m_busy) sclk_q <= cfg_cpol;
        else if (tick)      sclk_q <= ~sclk_q;
    end
    assign m_evt.lead  = m_busy && tick && (sclk_q == cfg_cpol);
    assign m_evt.trail = m_busy && tick && (sclk_q != cfg_cpol);

    // role selection
    assign evt    = cfg_slave ? s_evt : m_evt;
    assign start  = cfg_slave ? (s_sel_prev && !s_sel) : hold_full;
    assign abort  = cfg_slave && !s_sel_prev && s_sel;
    assign rx_bit = cfg_loop ? tx_bit : (cfg_slave ? s_rx : ser_rx_i);

    ssp_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_shift (
        .clk(clk), .rst(rst), .en(cfg_en), .slave(cfg_slave), .cpha(cfg_cpha),
        .nbits(nbits), .start(start), .abort(abort), .evt(evt), .rx_bit(rx_bit),
        .load_word(load_word), .accept(accept), .busy(busy), .tx_bit(tx_bit),
        .done(rx_valid), .rx_word(rx_data)
    );

    assign ser_clk_o   = m_busy ? sclk_q : cfg_cpol;
    assign ser_sel_n_o = !m_busy;
    assign ser_tx_oe   = cfg_en && !(cfg_slave && cfg_slave_tx_off);
    assign ser_tx_o    = ser_tx_oe && tx_bit;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic clk,
    input logic rst,
    input logic cfg_en,
    input logic cfg_slave,
    input logic cfg_slave_tx_off,
    input logic cfg_cpol,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic ser_clk_o,
    input logic ser_sel_n_o,
    input logic ser_tx_o,
    input logic ser_tx_oe
);
    p_rx_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_hold_full_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    p_start_take_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_sel_n_o) |-> (tx_ready && $past(!tx_ready)));

    p_disable_r7: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> (ser_sel_n_o && !rx_valid));

    p_tx_off_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_slave && cfg_slave_tx_off) |-> (!ser_tx_oe && !ser_tx_o));

    p_slave_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_slave |-> (ser_sel_n_o && ser_clk_o == cfg_cpol));
endmodule

bind sync_serial_port ssp_checker i_chk (.*);

// File: tb/test_sync_serial_port.sv
`timescale 1ns/1ps
module test_sync_serial_port;
    localparam int H = 16;

    logic clk = 0, rst = 1;
    logic cfg_en = 0, cfg_slave = 0, cfg_slave_tx_off = 0, cfg_loop = 0;
    logic cfg_cpol = 0, cfg_cpha = 0;
    logic [3:0] cfg_size = 4'd7;
    logic [7:0] cfg_prescale = 8'd2, cfg_rate = 8'd0;
    logic [15:0] tx_data = 0;
    logic tx_valid = 0;
    logic tx_ready, rx_valid, ser_clk_o, ser_sel_n_o, ser_tx_o, ser_tx_oe;
    logic [15:0] rx_data;
    logic s_clk = 0, s_sel = 1, s_mosi = 0;
    logic ser_rx_i;

    int checks = 0, fails = 0, rx_count = 0, cycles = 0;
    logic [15:0] last_rx = 0;

    always #2.5 clk = ~clk;

    assign ser_rx_i = cfg_slave ? s_mosi : ~ser_tx_o;

    sync_serial_port i_sync_serial_port (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_slave(cfg_slave),
        .cfg_slave_tx_off(cfg_slave_tx_off), .cfg_loop(cfg_loop),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_size(cfg_size),
        .cfg_prescale(cfg_prescale), .cfg_rate(cfg_rate),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .ser_clk_o(ser_clk_o), .ser_sel_n_o(ser_sel_n_o),
        .ser_tx_o(ser_tx_o), .ser_tx_oe(ser_tx_oe),
        .ser_clk_i(s_clk), .ser_sel_n_i(s_sel), .ser_rx_i(ser_rx_i)
    );

    always @(posedge clk) begin
        if (rx_valid) begin
            rx_count <= rx_count + 1;
            last_rx  <= rx_data;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int frame_len(input logic [3:0] sz);
        return (sz < 3) ? 4 : int'(sz) + 1;
    endfunction

    function automatic int half_len(input logic [7:0] pre, input logic [7:0] rate);
        int p = int'(pre) / 2;
        if (p < 1) p = 1;
        return p * (int'(rate) + 1);
    endfunction

    function automatic logic [15:0] lowmask(input int nb);
        return 16'((32'd1 << nb) - 1);
    endfunction

    task automatic push(input logic [15:0] d);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1; tx_data = d;
        @(negedge clk);
        tx_valid = 0;
    endtask

    task automatic wait_rx(input int base, output int cyc, output int toggles, output int half);
        logic prev = ser_clk_o;
        int t1 = -1;
        cyc = 0; toggles = 0; half = -1;
        while (rx_count == base && cyc < 20000) begin
            @(negedge clk); cyc++;
            if (ser_clk_o != prev) begin
                toggles++;
                if (toggles == 1) t1 = cyc;
                if (toggles == 2) half = cyc - t1;
            end
            prev = ser_clk_o;
        end
    endtask

    task automatic master_frame(input logic [15:0] d);
        int nb = frame_len(cfg_size);
        int base = rx_count, cyc, tg, hf;
        logic [15:0] exp_rx = (cfg_loop ? d : ~d) & lowmask(nb);
        push(d);
        wait_rx(base, cyc, tg, hf);
        check(rx_count == base + 1, "R5 one word per master frame", rx_count - base, 1);
        check(last_rx == exp_rx, cfg_loop ? "R10 master loopback word" : "R2 R3 master rx word", last_rx, exp_rx);
        check(tg == 2 * nb, "R2 clock transitions per frame", tg, 2 * nb);
        if (nb > 1) check(hf == half_len(cfg_prescale, cfg_rate), "R1 half period", hf, half_len(cfg_prescale, cfg_rate));
        check(ser_sel_n_o && ser_clk_o == cfg_cpol, "R4 R3 idle after frame", {ser_sel_n_o, ser_clk_o}, {1'b1, cfg_cpol});
    endtask

    task automatic slave_frame(input logic [15:0] mosi_w, input logic [15:0] txw, input logic use_tx);
        int nb = frame_len(cfg_size);
        int base = rx_count;
        logic [15:0] got = 0;
        logic [15:0] exp_miso = (use_tx && !cfg_slave_tx_off) ? (txw & lowmask(nb)) : 16'h0;
        logic [15:0] exp_rx = cfg_loop ? (use_tx ? (txw & lowmask(nb)) : 16'h0) : (mosi_w & lowmask(nb));
        if (use_tx) push(txw);
        @(negedge clk); s_clk = cfg_cpol; s_sel = 1;
        repeat (H) @(negedge clk);
        s_sel = 0;
        repeat (3 * H) @(negedge clk);
        check(ser_tx_oe == !cfg_slave_tx_off, "R9 slave output enable", ser_tx_oe, !cfg_slave_tx_off);
        for (int i = 0; i < nb; i++) begin
            if (!cfg_cpha) begin
                s_mosi = mosi_w[nb-1-i];
                repeat (H) @(negedge clk);
                got = {got[14:0], ser_tx_o};
                s_clk = ~s_clk;
                repeat (H) @(negedge clk);
                s_clk = ~s_clk;
            end else begin
                s_clk = ~s_clk;
                s_mosi = mosi_w[nb-1-i];
                repeat (H) @(negedge clk);
                got = {got[14:0], ser_tx_o};
                s_clk = ~s_clk;
                repeat (H) @(negedge clk);
            end
        end
        repeat (H) @(negedge clk);
        check(rx_count == base + 1, "R5 R8 one word per slave frame", rx_count - base, 1);
        check(last_rx == exp_rx, cfg_loop ? "R10 slave loopback word" : "R8 R3 slave rx word", last_rx, exp_rx);
        check(got == exp_miso, cfg_slave_tx_off ? "R9 gated slave data" : "R2 R6 slave tx bits", got, exp_miso);
        check(ser_sel_n_o && ser_clk_o == cfg_cpol, "R8 master pins idle in slave", {ser_sel_n_o, ser_clk_o}, {1'b1, cfg_cpol});
        s_sel = 1;
        repeat (2 * H) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        check(ser_sel_n_o == 1, "R11 select idle", ser_sel_n_o, 1);
        check(tx_ready == 1, "R11 holding empty", tx_ready, 1);
        check(rx_valid == 0, "R11 no rx pulse", rx_valid, 0);
        check(ser_tx_oe == 0, "R11 output disabled", ser_tx_oe, 0);
        check(ser_clk_o == cfg_cpol, "R11 clock idle", ser_clk_o, cfg_cpol);

        // R7 disabled port holds a queued word
        base = rx_count;
        push(16'h00A5);
        check(tx_ready == 0, "R6 holding full after accept", tx_ready, 0);
        repeat (300) begin
            @(negedge clk);
            if (!ser_sel_n_o) begin check(0, "R7 frame while disabled", 0, 1); break; end
        end
        check(rx_count == base, "R7 no word while disabled", rx_count - base, 0);
        cfg_en = 1;
        begin
            int cyc, tg, hf;
            wait_rx(base, cyc, tg, hf);
            check(last_rx == 16'h005A, "R7 queued word sent after enable", last_rx, 16'h005A);
        end

        // directed master corners
        cfg_size = 4'd1; cfg_prescale = 8'd5; cfg_rate = 8'd0; master_frame(16'hFFF3); // R2 clamp, R1 odd
        cfg_size = 4'd15; cfg_prescale = 8'd0; cfg_rate = 8'd0; master_frame(16'h8001); // R1 below 2
        cfg_size = 4'd3; cfg_prescale = 8'd254; cfg_rate = 8'd1; master_frame(16'h0009);
        cfg_size = 4'd15; cfg_prescale = 8'd2; cfg_rate = 8'd255; cfg_cpol = 1; cfg_cpha = 1; master_frame(16'h1234);
        cfg_loop = 1; cfg_size = 4'd9; cfg_prescale = 8'd4; cfg_rate = 8'd2; master_frame(16'hC2B7); // R10

        // random master frames
        for (int k = 0; k < 24; k++) begin
            cfg_cpol = 1'($urandom); cfg_cpha = 1'($urandom); cfg_loop = 1'($urandom);
            cfg_size = 4'(3 + $urandom % 13);
            cfg_prescale = 8'($urandom % 10); cfg_rate = 8'($urandom % 4);
            master_frame(16'($urandom));
        end

        // slave mode, all four clocking modes
        cfg_loop = 0; cfg_slave = 1;
        for (int m = 0; m < 4; m++) begin
            cfg_cpol = m[1]; cfg_cpha = m[0];
            cfg_size = 4'(3 + $urandom % 13);
            slave_frame(16'($urandom), 16'($urandom), 1'b1);
        end
        cfg_size = 4'd15; cfg_cpol = 0; cfg_cpha = 0;
        slave_frame(16'h5A3C, 16'h0000, 1'b0);          // R6 empty register sends zeros
        cfg_slave_tx_off = 1; cfg_cpha = 1;
        slave_frame(16'hA5C3, 16'hFFFF, 1'b1);          // R9
        cfg_slave_tx_off = 0; cfg_loop = 1; cfg_size = 4'd7;
        slave_frame(16'h00FF, 16'h0096, 1'b1);          // R10 in slave

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule